// File: doc/BRIEF.md
# Twin-Predicated Element Index Generator

This block drives the element loop of a two-operand operation such as a register move or a load. Each side of the operation has its own predicate mask, zeroing flag and vector flag. A `start` pulse loads the loop configuration. From then on the block emits at most one (source index, destination index) pair per clock. Each pair is tagged either as a data transfer or as a zero write. The block does no data movement. A data path next to it consumes the pairs.

Each side advances by itself. The source side passes over its own masked-out positions, and the destination side passes over its own masked-out positions. The same move therefore covers several cases:
- plain copy: both sides are vectors with no predicates.
- gather: only the source side is predicated.
- scatter: only the destination side is predicated.
- splat: a scalar source feeds a vector destination.
- extract: a vector source feeds a scalar destination.

The loop offsets sit in registers and are visible at all times. Trap handling can save them.

Top module: `twin_pred_idx`

## Requirements
- R1: After reset, `busy`, `emit_valid`, `emit_xfer`, `emit_zero` and `done` are 0, and both state offsets are 0.
- R2: A `start` pulse while idle latches `vl`, both masks and the four flags, and clears both offsets. A `start` pulse while busy is ignored, and the running loop continues with the latched configuration.
- R3: When the source side is a vector (`src_vec`=1) and `src_zero`=0, the emitted source index is always a position whose source mask bit (bit n for element n) is 1. Clear positions are passed over.
- R4: When `dst_vec`=1 and `dst_zero`=0, the emitted destination index is always a position whose destination mask bit is 1. Clear positions are passed over, independently of the source side.
- R5: After each emitted pair, the source index goes up by one only if `src_vec`=1, and the destination index goes up by one only if `dst_vec`=1. A scalar side stays at index 0.
- R6: With `dst_vec`=0, the loop emits at most one pair and raises `done` in the same cycle as that pair.
- R7: The loop ends, with `done` high for one cycle and no pair, when either index after skipping reaches the effective VL. The effective VL is `vl` clamped to MAXVL. With an effective VL of 0, no pair is emitted.
- R8: With `dst_zero`=1 and the destination mask bit at the destination index clear, the pair is a zero write (`emit_zero`=1).
- R9: With `src_zero`=1 and the source mask bit at the source index clear, the pair is a zero write. With zeroing on both sides, a zero is written wherever either bit is clear.
- R10: Every emitted pair has exactly one of `emit_xfer` and `emit_zero` set.
- R11: While busy, `state_src_off`/`state_dst_off` hold the loop's current index registers. These are 0 before the first pair and equal to the previous pair's index plus its increment afterwards.
- R12: When neither side is a vector, exactly one pair (0,0) is emitted, and then the loop finishes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a loop (ignored while busy) |
| vl | input | IW | Requested vector length |
| src_mask | input | MAXVL | Source predicate, bit n for element n |
| dst_mask | input | MAXVL | Destination predicate, bit n for element n |
| src_vec | input | 1 | Source operand is a vector |
| dst_vec | input | 1 | Destination operand is a vector |
| src_zero | input | 1 | Source zeroing mode |
| dst_zero | input | 1 | Destination zeroing mode |
| busy | output | 1 | Loop in progress |
| emit_valid | output | 1 | A pair is emitted this cycle |
| emit_src_idx | output | IW | Source element index of the pair |
| emit_dst_idx | output | IW | Destination element index of the pair |
| emit_xfer | output | 1 | Pair requests a data transfer |
| emit_zero | output | 1 | Pair requests a zero write |
| done | output | 1 | Last cycle of the loop |
| state_src_off | output | IW | Current source offset register |
| state_dst_off | output | IW | Current destination offset register |

## Verification
The bench targets the following failure modes, and names the wrong behaviour each one would expose:
- Sparse masks on one side only. A design that skipped on both sides together, or on the wrong side, would pair the wrong elements in gather and scatter.
- Scalar operands. A design that advanced a scalar side would read past element 0. A design that did not stop after one write to a scalar destination would write it repeatedly.
- Masks whose only set bits lie at or above VL, and a VL above MAXVL. Either would expose a search that runs off the end of the vector.
- A VL of zero, where a design that emitted one pair before checking the limit would be caught.
- The zeroing combinations, where a wrong policy would turn a transfer into a zero or the reverse.
- A second `start` mid-loop with changed masks, which would catch a design that relatched its configuration.

// File: rtl/twin_pred_idx.sv
module twin_pred_idx #(
  parameter int MAXVL = 16,
  localparam int IW = $clog2(MAXVL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IW-1:0]    vl,
  input  logic [MAXVL-1:0] src_mask,
  input  logic [MAXVL-1:0] dst_mask,
  input  logic             src_vec,
  input  logic             dst_vec,
  input  logic             src_zero,
  input  logic             dst_zero,
  output logic             busy,
  output logic             emit_valid,
  output logic [IW-1:0]    emit_src_idx,
  output logic [IW-1:0]    emit_dst_idx,
  output logic             emit_xfer,
  output logic             emit_zero,
  output logic             done,
  output logic [IW-1:0]    state_src_off,
  output logic [IW-1:0]    state_dst_off
);

  logic             busy_q;
  logic [IW-1:0]    vl_q, si_q, di_q;
  logic [MAXVL-1:0] sm_q, dm_q;
  logic             sv_q, dv_q, sz_q, dz_q;

  function automatic logic [IW-1:0] seek(input logic [MAXVL-1:0] m,
                                         input logic [IW-1:0] from,
                                         input logic [IW-1:0] lim);
    logic [IW-1:0] r;
    r = lim;
    for (int k = MAXVL - 1; k >= 0; k--)
      if (IW'(k) >= from && IW'(k) < lim && m[k]) r = IW'(k);
    return r;
  endfunction

  function automatic logic bit_at(input logic [MAXVL-1:0] m, input logic [IW-1:0] idx);
    logic [MAXVL:0] ext;
    ext = {1'b0, m};
    return ext[idx];
  endfunction

  logic [IW-1:0] ns, nd, vl_clamped;
  logic          end_c, zero_c;

  assign vl_clamped = (vl > IW'(MAXVL)) ? IW'(MAXVL) : vl;
  assign ns     = (sv_q && !sz_q) ? seek(sm_q, si_q, vl_q) : si_q;
  assign nd     = (dv_q && !dz_q) ? seek(dm_q, di_q, vl_q) : di_q;
  assign end_c  = (ns >= vl_q) || (nd >= vl_q);
  assign zero_c = (sz_q && !bit_at(sm_q, ns)) || (dz_q && !bit_at(dm_q, nd));

  assign busy          = busy_q;
  assign emit_valid    = busy_q && !end_c;
  assign emit_src_idx  = ns;
  assign emit_dst_idx  = nd;
  assign emit_xfer     = emit_valid && !zero_c;
  assign emit_zero     = emit_valid && zero_c;
  assign done          = busy_q && (end_c || !dv_q);
  assign state_src_off = si_q;
  assign state_dst_off = di_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      vl_q   <= '0;
      si_q   <= '0;
      di_q   <= '0;
      sm_q   <= '0;
      dm_q   <= '0;
      sv_q   <= 1'b0;
      dv_q   <= 1'b0;
      sz_q   <= 1'b0;
      dz_q   <= 1'b0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        vl_q   <= vl_clamped;
        sm_q   <= src_mask;
        dm_q   <= dst_mask;
        sv_q   <= src_vec;
        dv_q   <= dst_vec;
        sz_q   <= src_zero;
        dz_q   <= dst_zero;
        si_q   <= '0;
        di_q   <= '0;
      end
    end else begin
      if (done) busy_q <= 1'b0;
      if (emit_valid) begin
        si_q <= ns + {{(IW-1){1'b0}}, sv_q};
        di_q <= nd + {{(IW-1){1'b0}}, dv_q};
      end
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !busy && !emit_valid && !done); // R1
  AST_SRC_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    emit_valid && sv_q && !sz_q |-> bit_at(sm_q, emit_src_idx)); // R3
  AST_DST_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    emit_valid && dv_q && !dz_q |-> bit_at(dm_q, emit_dst_idx)); // R4
  AST_SCALAR_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    emit_valid && !sv_q |-> emit_src_idx == '0); // R5
  AST_DST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    emit_valid && $past(emit_valid) && dv_q |-> emit_dst_idx > $past(emit_dst_idx)); // R5
  AST_SCALAR_DST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    emit_valid && !dv_q |-> done); // R6
  AST_BELOW_VL: assert property (@(posedge clk) disable iff (!rst_n)
    emit_valid |-> emit_src_idx < vl_q && emit_dst_idx < vl_q); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R7
  AST_KIND_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    emit_valid |-> $countones({emit_xfer, emit_zero}) == 1); // R10
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && !$past(done) |-> $stable(vl_q)); // R2

endmodule

// File: tb/twin_pred_idx_test.sv
module twin_pred_idx_test;
  localparam int MAXVL = 16;
  localparam int IW = $clog2(MAXVL + 1);
  localparam int NROW = 14;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [IW-1:0] vl = '0;
  logic [MAXVL-1:0] src_mask = '0, dst_mask = '0;
  logic src_vec = 1'b0, dst_vec = 1'b0, src_zero = 1'b0, dst_zero = 1'b0;
  logic busy, emit_valid, emit_xfer, emit_zero, done;
  logic [IW-1:0] emit_src_idx, emit_dst_idx, state_src_off, state_dst_off;

  int nchk = 0, nfail = 0;

  always #10 clk = ~clk;

  twin_pred_idx #(.MAXVL(MAXVL)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl),
    .src_mask(src_mask), .dst_mask(dst_mask),
    .src_vec(src_vec), .dst_vec(dst_vec), .src_zero(src_zero), .dst_zero(dst_zero),
    .busy(busy), .emit_valid(emit_valid), .emit_src_idx(emit_src_idx),
    .emit_dst_idx(emit_dst_idx), .emit_xfer(emit_xfer), .emit_zero(emit_zero),
    .done(done), .state_src_off(state_src_off), .state_dst_off(state_dst_off));

  // {vl, src_mask, dst_mask, sv dv sz dz, expected pair count}
  localparam logic [45:0] TBL [NROW] = '{
    {5'd8,  16'hFFFF, 16'hFFFF, 4'b1100, 5'd8},
    {5'd8,  16'h00AA, 16'hFFFF, 4'b1100, 5'd4},
    {5'd8,  16'hFFFF, 16'h0055, 4'b1100, 5'd4},
    {5'd5,  16'h0000, 16'h001B, 4'b0100, 5'd4},
    {5'd8,  16'h0020, 16'h0000, 4'b1000, 5'd1},
    {5'd8,  16'h0000, 16'h0000, 4'b0000, 5'd1},
    {5'd6,  16'hFFFF, 16'h0015, 4'b1101, 5'd6},
    {5'd6,  16'h0033, 16'h003C, 4'b1111, 5'd6},
    {5'd0,  16'hFFFF, 16'hFFFF, 4'b1100, 5'd0},
    {5'd20, 16'hFFFF, 16'hFFFF, 4'b1100, 5'd16},
    {5'd8,  16'h0000, 16'hFFFF, 4'b1100, 5'd0},
    {5'd4,  16'h0005, 16'h000F, 4'b1110, 5'd4},
    {5'd8,  16'h00F0, 16'h000F, 4'b1100, 5'd4},
    {5'd3,  16'h0020, 16'h0000, 4'b1000, 5'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string row_tag(input int r);
    case (r)
      0: return "R2";   1: return "R3";   2: return "R4";  3: return "R5";
      4: return "R6";   5: return "R12";  6: return "R8";  7: return "R9";
      8: return "R7";   9: return "R7";  10: return "R3"; 11: return "R9";
      12: return "R4"; default: return "R7";
    endcase
  endfunction

  task automatic run_row(input int r, input bit poke);
    logic [45:0] e;
    int evl, i, j, n, k;
    int es[32], ed[32];
    bit ez[32];
    bit sv, dv, sz, dz, seen_done;
    string tag;
    e = TBL[r];
    tag = row_tag(r);
    sv = e[8]; dv = e[7]; sz = e[6]; dz = e[5];
    evl = (int'(e[45:41]) > MAXVL) ? MAXVL : int'(e[45:41]);
    // reference pairing from the requirements
    i = 0; j = 0; n = 0;
    while (i < evl && j < evl) begin
      if (sv && !sz) while (i < evl && !e[25 + i]) i++;
      if (dv && !dz) while (j < evl && !e[9 + j]) j++;
      if (i >= evl || j >= evl) break;
      es[n] = i; ed[n] = j;
      ez[n] = (sz && !e[25 + i]) || (dz && !e[9 + j]);
      n++;
      if (!dv) break;
      if (sv) i++;
      j++;
    end
    @(negedge clk);
    vl = e[45:41]; src_mask = e[40:25]; dst_mask = e[24:9];
    src_vec = sv; dst_vec = dv; src_zero = sz; dst_zero = dz;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 0; seen_done = 1'b0;
    for (int c = 0; c < 40; c++) begin
      if (emit_valid) begin
        if (k < n) begin
          chk(tag, {emit_src_idx, emit_dst_idx, emit_xfer, emit_zero},
              {IW'(es[k]), IW'(ed[k]), !ez[k], ez[k]});
          chk("R11", {state_src_off, state_dst_off},
              (k == 0) ? '0 : {IW'(es[k-1] + int'(sv)), IW'(ed[k-1] + int'(dv))});
        end
        chk("R10", 32'(emit_xfer ^ emit_zero), 32'd1);
        k++;
      end
      if (poke && c == 1) begin
        start = 1'b1; src_mask = ~src_mask; dst_mask = ~dst_mask; vl = 5'd2;
      end
      seen_done = done;
      @(negedge clk);
      start = 1'b0;
      if (seen_done) break;
    end
    chk(tag, 32'(seen_done), 32'd1);
    chk(tag, 32'(k), 32'(n));
    chk(tag, 32'(k), 32'(e[4:0]));
    chk("R7", 32'(busy), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", {busy, emit_valid, emit_xfer, emit_zero, done}, 5'b0);
    chk("R1", {state_src_off, state_dst_off}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {busy, emit_valid, done}, 3'b0);
    for (int r = 0; r < NROW; r++) run_row(r, r == 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule